// File: doc/BRIEF.md
# Line-Tagged Receive Queue

This block is a circular receive queue that is shared by four serial lines. Each entry holds one 8-bit character and the 2-bit number of the line that delivered it. A push port writes a character and its line number in one cycle. A pop port returns the oldest entry, with a data-valid flag, on the cycle after the request. The queue reports whether it is empty and how many entries it holds.

A flow policy protects the queue from a chatty pointing device. One line is designated as the pointer-device line. Once the queue holds more than half of its capacity, pushes from that line are discarded without any report. Pushes from the other lines are accepted until the queue is full. A push that finds the queue full, with no pop in the same cycle, is lost. That loss sets a sticky overrun flag, which a clear pulse resets.

Top module: `line_rx_queue`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block empties the queue. `q_count` is 0, `q_empty` is 1, `ovr_flag` is 0, and `pop_vld`, `pop_char` and `pop_line` are 0.
- R2: A pop at edge N on a non-empty queue removes the oldest stored entry. After edge N, `pop_vld` is 1 and `pop_char` and `pop_line` hold that entry's character and line number. Entries leave in the order they were accepted.
- R3: A pop at an edge where the queue is empty returns `pop_vld`=0, `pop_char`=0 and `pop_line`=0, and it leaves `q_count` unchanged.
- R4: `q_count` equals accepted pushes minus successful pops, within 0..DEPTH. `q_empty` is 1 exactly when `q_count` is 0.
- R5: A push whose line number equals `MOUSE_LINE` is discarded when `q_count` is greater than DEPTH/2 at that edge. A discarded push does not change `q_count` and does not set `ovr_flag`. At exactly DEPTH/2 such a push is accepted.
- R6: A push from any other line number (0..3) is accepted whenever `q_count` is below DEPTH.
- R7: A push that is not discarded under R5, arriving while `q_count` equals DEPTH with no pop in the same edge, is lost. It sets `ovr_flag`, and `q_count` stays at DEPTH.
- R8: `ovr_flag` stays at 1 until an edge with `ovr_clr` high clears it. If an overrun and `ovr_clr` occur at the same edge, the flag ends at 1.
- R9: A push and a pop at the same edge are both served, and `q_count` is unchanged. This also holds when the queue is full. When the queue is empty, the pop returns the invalid result of R3 and the push is stored, so `q_count` becomes 1.
- R10: Both pointers wrap at DEPTH. Order and line tags stay correct across many passes around the storage.
- R11: On every cycle that does not follow a pop, `pop_vld`, `pop_char` and `pop_line` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_vld | input | 1 | Push request |
| push_char | input | 8 | Character to store |
| push_line | input | 2 | Line number of the character (0..3) |
| pop_req | input | 1 | Pop request |
| ovr_clr | input | 1 | Clears the overrun flag |
| pop_vld | output | 1 | The pop result holds a real entry |
| pop_char | output | 8 | Character of the popped entry, else 0 |
| pop_line | output | 2 | Line number of the popped entry, else 0 |
| q_empty | output | 1 | Queue holds no entries |
| q_count | output | $clog2(DEPTH)+1 | Number of stored entries |
| ovr_flag | output | 1 | Sticky overrun indicator |

## Verification
The bench builds the queue with DEPTH=8 and MOUSE_LINE=3. With that depth, the half-capacity threshold, the full condition and pointer wrap-around are each only a few pushes away. The bench can therefore probe the mouse-drop boundary at exactly four and five entries. It also covers an overrun with and without a same-cycle clear, and simultaneous push and pop at both full and empty. A streaming phase then runs many passes around the eight slots, so stale storage or a wrong wrap would show up as misordered entries or wrong line tags.

// File: rtl/lrq_pkg.sv
// Shared widths and the stored entry type of the line-tagged receive queue.
// Assumes four serial lines and byte-wide characters.
package lrq_pkg;
    localparam int LRQ_CHAR_W = 8;
    localparam int LRQ_LINE_W = 2;

    typedef struct packed {
        logic [LRQ_LINE_W-1:0] line;
        logic [LRQ_CHAR_W-1:0] ch;
    } lrq_entry_t;
endpackage

// File: rtl/lrq_ptrs.sv
// Read/write pointer pair with one extra wrap bit. It yields the storage
// addresses, the occupancy, and the empty and full conditions.
// Assumes DEPTH is a power of two and that callers never write when full
// or read when empty.
module lrq_ptrs #(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    output logic [$clog2(DEPTH)-1:0] wr_addr,
    output logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [$clog2(DEPTH):0]   occupancy,
    output logic                     empty,
    output logic                     full
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    // Advance each pointer on its own enable; the extra bit records the lap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + PW'(1);
            if (rd_en) rd_ptr <= rd_ptr + PW'(1);
        end
    end

    // Decode addresses, the modular distance and the boundary conditions.
    always_comb begin
        wr_addr   = wr_ptr[AW-1:0];
        rd_addr   = rd_ptr[AW-1:0];
        occupancy = wr_ptr - rd_ptr;
        empty     = (wr_ptr == rd_ptr);
        full      = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    end
endmodule

// File: rtl/lrq_store.sv
// Entry storage of the queue: synchronous write and asynchronous read of
// the head slot. Holds no reset, because slots are only read after a write.
module lrq_store
    import lrq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  lrq_entry_t               wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output lrq_entry_t               rdata
);
    lrq_entry_t slots [DEPTH];

    // Capture an accepted push into its slot.
    always_ff @(posedge clk) begin
        if (we) slots[waddr] <= wdata;
    end

    // Present the head slot to the pop path.
    always_comb rdata = slots[raddr];
endmodule

// File: rtl/lrq_admit.sv
// Admission policy for pushes. It discards pointer-device traffic once more
// than half of the queue is occupied, and it flags a push that finds no room.
// Assumes a same-cycle successful pop frees one slot.
module lrq_admit
    import lrq_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int MOUSE_LINE = 1
) (
    input  logic                  push_vld,
    input  logic [LRQ_LINE_W-1:0] push_line,
    input  logic [$clog2(DEPTH):0] occupancy,
    input  logic                  full,
    input  logic                  pop_ok,
    output logic                  wr_en,
    output logic                  ovr_set
);
    localparam int PW = $clog2(DEPTH) + 1;
    localparam logic [PW-1:0]         HALF  = PW'(DEPTH / 2);
    localparam logic [LRQ_LINE_W-1:0] MLINE = LRQ_LINE_W'(MOUSE_LINE);

    logic mouse_drop;
    logic no_room;

    // Decide, per push, between store, silent drop and overrun.
    always_comb begin
        mouse_drop = push_vld && (push_line == MLINE) && (occupancy > HALF);
        no_room    = full && !pop_ok;
        wr_en      = push_vld && !mouse_drop && !no_room;
        ovr_set    = push_vld && !mouse_drop && no_room;
    end
endmodule

// File: rtl/line_rx_queue.sv
// Line-tagged receive queue shared by four serial lines. Pushes carry a
// character and its line number; pops return the oldest entry one cycle
// later with a valid flag, or all zeros if empty. Pointer-device pushes are
// discarded beyond half occupancy; a push into a full queue sets a sticky
// overrun flag. Assumes DEPTH is a power of two and at least 4.
module line_rx_queue
    import lrq_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int MOUSE_LINE = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_vld,
    input  logic [LRQ_CHAR_W-1:0]    push_char,
    input  logic [LRQ_LINE_W-1:0]    push_line,
    input  logic                     pop_req,
    input  logic                     ovr_clr,
    output logic                     pop_vld,
    output logic [LRQ_CHAR_W-1:0]    pop_char,
    output logic [LRQ_LINE_W-1:0]    pop_line,
    output logic                     q_empty,
    output logic [$clog2(DEPTH):0]   q_count,
    output logic                     ovr_flag
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic          empty;
    logic          full;
    logic          rd_en;
    logic          wr_en;
    logic          ovr_set;
    lrq_entry_t    head;
    lrq_entry_t    wentry;

    // A pop is served only when an entry is present.
    always_comb begin
        rd_en  = pop_req && !empty;
        wentry = '{line: push_line, ch: push_char};
    end

    lrq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .occupancy (q_count),
        .empty     (empty),
        .full      (full)
    );

    lrq_admit #(.DEPTH(DEPTH), .MOUSE_LINE(MOUSE_LINE)) u_admit (
        .push_vld  (push_vld),
        .push_line (push_line),
        .occupancy (q_count),
        .full      (full),
        .pop_ok    (rd_en),
        .wr_en     (wr_en),
        .ovr_set   (ovr_set)
    );

    lrq_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wentry),
        .raddr (rd_addr),
        .rdata (head)
    );

    // Register the pop result; zeros on any cycle without a served pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_vld  <= 1'b0;
            pop_char <= '0;
            pop_line <= '0;
        end else if (rd_en) begin
            pop_vld  <= 1'b1;
            pop_char <= head.ch;
            pop_line <= head.line;
        end else begin
            pop_vld  <= 1'b0;
            pop_char <= '0;
            pop_line <= '0;
        end
    end

    // Sticky overrun: a new overrun wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr_flag <= 1'b0;
        else if (ovr_set) ovr_flag <= 1'b1;
        else if (ovr_clr) ovr_flag <= 1'b0;
    end

    assign q_empty = empty;
endmodule

// File: rtl/lrq_chk.sv
// Port-level temporal checks for the line-tagged receive queue, bound into
// every instance of the top module.
module lrq_chk
    import lrq_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int MOUSE_LINE = 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  push_vld,
    input logic [LRQ_LINE_W-1:0] push_line,
    input logic                  pop_req,
    input logic                  ovr_clr,
    input logic                  pop_vld,
    input logic [LRQ_CHAR_W-1:0] pop_char,
    input logic [LRQ_LINE_W-1:0] pop_line,
    input logic                  q_empty,
    input logic [$clog2(DEPTH):0] q_count,
    input logic                  ovr_flag
);
    localparam int PW = $clog2(DEPTH) + 1;
    localparam logic [PW-1:0]         HALF  = PW'(DEPTH / 2);
    localparam logic [PW-1:0]         FULLC = PW'(DEPTH);
    localparam logic [LRQ_LINE_W-1:0] MLINE = LRQ_LINE_W'(MOUSE_LINE);

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= FULLC);

    assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && q_empty |=> !pop_vld && pop_char == '0 && pop_line == '0);

    assert_pop_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && !q_empty |=> pop_vld);

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_req |=> !pop_vld);

    assert_mouse_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push_vld && push_line == MLINE && q_count > HALF && !pop_req && !ovr_clr
        |=> q_count == $past(q_count) && ovr_flag == $past(ovr_flag));

    assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push_vld && push_line != MLINE && q_count == FULLC && !pop_req |=> ovr_flag);

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag && !ovr_clr |=> ovr_flag);

    assert_push_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push_vld && push_line != MLINE && pop_req && !q_empty
        |=> q_count == $past(q_count));
endmodule

bind line_rx_queue lrq_chk #(.DEPTH(DEPTH), .MOUSE_LINE(MOUSE_LINE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_vld  (push_vld),
    .push_line (push_line),
    .pop_req   (pop_req),
    .ovr_clr   (ovr_clr),
    .pop_vld   (pop_vld),
    .pop_char  (pop_char),
    .pop_line  (pop_line),
    .q_empty   (q_empty),
    .q_count   (q_count),
    .ovr_flag  (ovr_flag)
);

// File: tb/sim_line_rx_queue.sv
`timescale 1ns/1ps
module sim_line_rx_queue;
    localparam int DEPTH = 8;
    localparam int MOUSE = 3;
    localparam int PW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_vld = 1'b0;
    logic [7:0]    push_char = '0;
    logic [1:0]    push_line = '0;
    logic          pop_req = 1'b0;
    logic          ovr_clr = 1'b0;
    logic          pop_vld;
    logic [7:0]    pop_char;
    logic [1:0]    pop_line;
    logic          q_empty;
    logic [PW-1:0] q_count;
    logic          ovr_flag;

    int checks = 0;
    int errors = 0;

    bit [9:0]  mq[$];    // model contents {line, char}
    bit [10:0] sbq[$];   // expected pop results {valid, line, char}
    bit        m_ovr = 1'b0;
    bit        pop_seen = 1'b0;

    always #2.5 clk = ~clk;

    line_rx_queue #(.DEPTH(DEPTH), .MOUSE_LINE(MOUSE)) u0 (
        .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_char(push_char),
        .push_line(push_line), .pop_req(pop_req), .ovr_clr(ovr_clr),
        .pop_vld(pop_vld), .pop_char(pop_char), .pop_line(pop_line),
        .q_empty(q_empty), .q_count(q_count), .ovr_flag(ovr_flag)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: note served-pop cycles, then compare at the following falling edge.
    always @(posedge clk) pop_seen <= pop_req && rst_n;

    always @(negedge clk) begin
        if (pop_seen) begin
            bit [10:0] e;
            e = (sbq.size() > 0) ? sbq.pop_front() : 11'h7ff;
            check({pop_vld, pop_line, pop_char} == e, e[10] ? "R2 pop entry" : "R3 empty pop",
                  int'({pop_vld, pop_line, pop_char}), int'(e));
        end else if (rst_n) begin
            check({pop_vld, pop_line, pop_char} == 11'd0, "R11 idle output",
                  int'({pop_vld, pop_line, pop_char}), 0);
        end
    end

    // Driver: one cycle of stimulus, model update, then state checks.
    task automatic op(input bit pu, input bit [7:0] c, input bit [1:0] l,
                      input bit po, input bit cl, input string tag);
        int  occ;
        bit  set_o;
        occ   = mq.size();
        set_o = 1'b0;
        if (po) begin
            if (occ > 0) sbq.push_back({1'b1, mq.pop_front()});
            else         sbq.push_back(11'd0);
        end
        if (pu) begin
            if (l == 2'(MOUSE) && occ > DEPTH / 2) ;
            else if (occ == DEPTH && !po) set_o = 1'b1;
            else mq.push_back({l, c});
        end
        if (set_o) m_ovr = 1'b1;
        else if (cl) m_ovr = 1'b0;
        push_vld = pu; push_char = c; push_line = l; pop_req = po; ovr_clr = cl;
        @(posedge clk); #1;
        push_vld = 1'b0; pop_req = 1'b0; ovr_clr = 1'b0;
        check(int'(q_count) == mq.size(), {tag, " count"}, int'(q_count), mq.size());
        check(q_empty == (mq.size() == 0), {tag, " empty R4"}, int'(q_empty), int'(mq.size() == 0));
        check(ovr_flag == m_ovr, {tag, " overrun"}, int'(ovr_flag), int'(m_ovr));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(q_count == '0, "R1 count", int'(q_count), 0);
        check(q_empty == 1'b1, "R1 empty", int'(q_empty), 1);
        check(ovr_flag == 1'b0, "R1 overrun", int'(ovr_flag), 0);
        check(pop_vld == 1'b0, "R1 pop_vld", int'(pop_vld), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        op(0, 8'h00, 0, 1, 0, "R3");                      // pop on empty
        op(1, 8'h41, 0, 0, 0, "R4");                      // basic pushes, R2 order
        op(1, 8'h42, 1, 0, 0, "R4");
        op(1, 8'h43, 2, 0, 0, "R4");
        op(0, 8'h00, 0, 0, 0, "R11");
        for (int i = 0; i < 3; i++) op(0, 8'h00, 0, 1, 0, "R2");
        op(0, 8'h00, 0, 1, 0, "R3");

        // R5 / R6 / R7: threshold, drops and overrun
        for (int i = 0; i < 4; i++) op(1, 8'h10 + 8'(i), 2'(i % 3), 0, 0, "R6");
        op(1, 8'hA0, 2'(MOUSE), 0, 0, "R5 at half");      // accepted at 4
        op(1, 8'hA1, 2'(MOUSE), 0, 0, "R5 drop");         // dropped at 5
        for (int i = 0; i < 3; i++) op(1, 8'h20 + 8'(i), 0, 0, 0, "R6");
        op(1, 8'hEE, 1, 0, 0, "R7 overrun");
        op(1, 8'hA2, 2'(MOUSE), 0, 0, "R5 full drop");
        op(0, 8'h00, 0, 0, 0, "R8 sticky");
        op(0, 8'h00, 0, 0, 1, "R8 clear");

        // R9: push and pop together at full; R8 set beats clear
        op(1, 8'h55, 2, 1, 0, "R9 full");
        op(1, 8'h66, 1, 0, 1, "R8 set wins");
        op(0, 8'h00, 0, 0, 1, "R8 clear");
        for (int i = 0; i < DEPTH; i++) op(0, 8'h00, 0, 1, 0, "R2 drain");
        op(1, 8'h77, 2, 1, 0, "R9 empty");                 // invalid pop, push kept
        op(0, 8'h00, 0, 1, 0, "R2");

        // R10: stream around the storage many times
        for (int i = 0; i < 3; i++) op(1, 8'h80 + 8'(i), 2'(i), 0, 0, "R10 fill");
        for (int i = 0; i < 40; i++)
            op(1, 8'(i * 7 + 1), 2'(i % 3), 1, 0, "R10 stream");
        for (int i = 0; i < 3; i++) op(0, 8'h00, 0, 1, 0, "R10 drain");
        op(0, 8'h00, 0, 0, 0, "R10 end");
        @(posedge clk); #1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule